// File: doc/BRIEF.md
# Thirty-Two Line GPIO Bank with Interrupt Front End

This block is one bank of general-purpose I/O lines behind a small single-cycle register bus. Software sets what each line drives, whether the line is an output or an input, and whether an output line blinks. It also sets the active level of each input and enables interrupts per line. Every pad input passes through a two-flop synchroniser. It is then XORed with its polarity bit to form the data-in value that software reads.

The same data-in value feeds the interrupt logic in two ways. A level interrupt uses data-in directly. An edge interrupt comes from a sticky cause bit, which is set when data-in goes from 0 to 1 and is cleared by software. Each enabled per-line request is ORed with the others in its group of eight. The result is four summary interrupt outputs, which go to the chip's interrupt controller.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset the output-data, blink, polarity, edge-mask, level-mask and edge-cause registers read 0, the direction register reads all ones (every line an input), pad_oe is 0 and irq_sum is 0.
- R2: Registers are selected by bus_addr (byte offset bits 4:2): 0 output data, 1 direction, 2 blink enable, 3 polarity, 4 data-in (read-only, writes ignored), 5 edge cause, 6 edge mask, 7 level mask. The value written to a read/write register reads back unchanged.
- R3: A direction bit of 0 makes the line an output: pad_oe is high for that line, and with blink off pad_out equals the output-data bit. A direction bit of 1 makes pad_oe low for that line.
- R4: Data-in bit n equals the pad input n, delayed through two flops, XOR polarity bit n. A polarity bit of 1 therefore makes the line active-low.
- R5: A 0-to-1 change of a data-in bit sets the matching edge-cause bit one clock after data-in changes, and the bit stays set. A 1-to-0 change sets nothing.
- R6: A write to the edge-cause register clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R7: The request for line n is (data-in AND level mask) OR (edge cause AND edge mask). irq_sum[g] is the OR of the requests of lines 8g to 8g+7. With both masks zero, irq_sum is 0.
- R8: If a rising edge and a clearing write hit the same edge-cause bit in one clock, the bit ends up set.
- R9: An output line with its blink bit set shows the output-data bit XOR a toggle that flips every BLINK_DIV clocks. An input line, or a line with its blink bit clear, is not affected by blinking.
- R10: A read request returns the register value on rd_data, with rd_valid high, in the clock after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register index (byte offset bits 4:2) |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data |
| rd_valid | output | 1 | Read data valid, one clock after a read |
| pad_in | input | 32 | Pad input levels |
| pad_out | output | 32 | Pad output levels |
| pad_oe | output | 32 | Pad output enables |
| irq_sum | output | 4 | Summary interrupts, one per group of eight lines |

## Verification
The properties assume that reset is applied before any stimulus and that every bus request lasts exactly one clock. They also assume that the pad inputs are low while reset is held, so that the first synchronised sample cannot produce a spurious edge. The bench drives the bus and the pads only at falling edges. It releases reset with the pads at zero. It waits at least four clocks after a pad or polarity change before reading data-in or edge cause, so that the synchroniser and edge stage have settled. The one exception is the set-versus-clear case, where the write is deliberately placed in the clock in which the cause bit is set.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  typedef enum logic [2:0] {
    RSEL_OUT   = 3'd0,
    RSEL_DIR   = 3'd1,
    RSEL_BLINK = 3'd2,
    RSEL_POL   = 3'd3,
    RSEL_DIN   = 3'd4,
    RSEL_CAUSE = 3'd5,
    RSEL_EMASK = 3'd6,
    RSEL_LMASK = 3'd7
  } rsel_e;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = d_in;
    for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= stage_d[s];
    end
  end

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_valid,
  input  logic         bus_write,
  input  logic [2:0]   bus_sel,
  input  logic [W-1:0] bus_wdata,
  input  logic [W-1:0] din,
  input  logic [W-1:0] cause,
  output logic [W-1:0] rd_data,
  output logic         rd_valid,
  output logic [W-1:0] out_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] blink_q,
  output logic [W-1:0] pol_q,
  output logic [W-1:0] emask_q,
  output logic [W-1:0] lmask_q,
  output logic         cause_wr
);
  rsel_e        sel;
  logic         wr, rd;
  logic         en_out, en_dir, en_blink, en_pol, en_emask, en_lmask;
  logic [W-1:0] rmux;

  assign sel = rsel_e'(bus_sel);
  assign wr  = bus_valid & bus_write;
  assign rd  = bus_valid & ~bus_write;

  always_comb begin
    en_out   = wr && (sel == RSEL_OUT);
    en_dir   = wr && (sel == RSEL_DIR);
    en_blink = wr && (sel == RSEL_BLINK);
    en_pol   = wr && (sel == RSEL_POL);
    en_emask = wr && (sel == RSEL_EMASK);
    en_lmask = wr && (sel == RSEL_LMASK);
    cause_wr = wr && (sel == RSEL_CAUSE);
  end

  always_comb begin
    unique case (sel)
      RSEL_OUT:   rmux = out_q;
      RSEL_DIR:   rmux = dir_q;
      RSEL_BLINK: rmux = blink_q;
      RSEL_POL:   rmux = pol_q;
      RSEL_DIN:   rmux = din;
      RSEL_CAUSE: rmux = cause;
      RSEL_EMASK: rmux = emask_q;
      RSEL_LMASK: rmux = lmask_q;
      default:    rmux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      dir_q   <= '1;
      blink_q <= '0;
      pol_q   <= '0;
      emask_q <= '0;
      lmask_q <= '0;
    end else begin
      if (en_out)   out_q   <= bus_wdata;
      if (en_dir)   dir_q   <= bus_wdata;
      if (en_blink) blink_q <= bus_wdata;
      if (en_pol)   pol_q   <= bus_wdata;
      if (en_emask) emask_q <= bus_wdata;
      if (en_lmask) lmask_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd;
      if (rd) rd_data <= rmux;
    end
  end
endmodule

// File: rtl/gpio_bank_edge.sv
module gpio_bank_edge #(
  parameter int W     = 32,
  parameter int GROUP = 8,
  localparam int NGRP = W / GROUP
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    din,
  input  logic            cause_wr,
  input  logic [W-1:0]    cause_wdata,
  input  logic [W-1:0]    emask,
  input  logic [W-1:0]    lmask,
  output logic [W-1:0]    prev_q,
  output logic [W-1:0]    cause_q,
  output logic [NGRP-1:0] irq_sum
);
  logic [W-1:0] rise, keep, cause_d, req;

  always_comb begin
    rise    = din & ~prev_q;
    keep    = cause_wr ? cause_wdata : '1;
    cause_d = (cause_q & keep) | rise;
    req     = (din & lmask) | (cause_q & emask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      cause_q <= '0;
    end else begin
      prev_q  <= din;
      cause_q <= cause_d;
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_sum
    assign irq_sum[g] = |req[g*GROUP +: GROUP];
  end
endmodule

// File: rtl/gpio_bank_blink.sv
module gpio_bank_blink #(
  parameter int DIV = 1024,
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic tog_q
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          tog_d, wrap;

  always_comb begin
    wrap  = (cnt_q == CW'(DIV - 1));
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
    tog_d = wrap ? ~tog_q : tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tog_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tog_q <= tog_d;
    end
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int W         = 32,
  parameter int GROUP     = 8,
  parameter int SYNC      = 2,
  parameter int BLINK_DIV = 1024,
  localparam int NGRP     = W / GROUP
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_valid,
  input  logic            bus_write,
  input  logic [2:0]      bus_addr,
  input  logic [W-1:0]    bus_wdata,
  output logic [W-1:0]    rd_data,
  output logic            rd_valid,
  input  logic [W-1:0]    pad_in,
  output logic [W-1:0]    pad_out,
  output logic [W-1:0]    pad_oe,
  output logic [NGRP-1:0] irq_sum
);
  logic [W-1:0] sync_w, din_w, prev_w, cause_w;
  logic [W-1:0] out_w, dir_w, blink_w, pol_w, emask_w, lmask_w;
  logic         cause_wr_w, tog_w;

  gpio_bank_sync #(.W(W), .STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(pad_in), .d_out(sync_w)
  );

  assign din_w = sync_w ^ pol_w;

  gpio_bank_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_sel(bus_addr), .bus_wdata(bus_wdata),
    .din(din_w), .cause(cause_w),
    .rd_data(rd_data), .rd_valid(rd_valid),
    .out_q(out_w), .dir_q(dir_w), .blink_q(blink_w), .pol_q(pol_w),
    .emask_q(emask_w), .lmask_q(lmask_w), .cause_wr(cause_wr_w)
  );

  gpio_bank_edge #(.W(W), .GROUP(GROUP)) u_edge (
    .clk(clk), .rst_n(rst_n), .din(din_w),
    .cause_wr(cause_wr_w), .cause_wdata(bus_wdata),
    .emask(emask_w), .lmask(lmask_w),
    .prev_q(prev_w), .cause_q(cause_w), .irq_sum(irq_sum)
  );

  gpio_bank_blink #(.DIV(BLINK_DIV)) u_blink (
    .clk(clk), .rst_n(rst_n), .tog_q(tog_w)
  );

  assign pad_oe  = ~dir_w;
  assign pad_out = out_w ^ (blink_w & ~dir_w & {W{tog_w}});
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_valid,
  input logic         bus_write,
  input logic [2:0]   bus_addr,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] din_w,
  input logic [W-1:0] prev_w,
  input logic [W-1:0] cause_w,
  input logic [W-1:0] out_w,
  input logic [W-1:0] dir_w,
  input logic [W-1:0] blink_w,
  input logic [W-1:0] emask_w,
  input logic [W-1:0] lmask_w,
  input logic [W-1:0] pad_out,
  input logic [3:0]   irq_sum
);
  logic clr_wr;
  assign clr_wr = bus_valid && bus_write && (bus_addr == 3'd5);

  for (genvar i = 0; i < W; i++) begin : g_line
    assert_edge_latched_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (din_w[i] && !prev_w[i]) |=> cause_w[i]);
    assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (din_w[i] && !prev_w[i] && clr_wr && !bus_wdata[i]) |=> cause_w[i]);
    assert_cause_needs_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cause_w[i] && !(din_w[i] && !prev_w[i])) |=> !cause_w[i]);
    assert_cause_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_w[i] && !(clr_wr && !bus_wdata[i])) |=> cause_w[i]);
    assert_plain_output_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!blink_w[i]) |-> (pad_out[i] == out_w[i]));
  end

  assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (emask_w == '0 && lmask_w == '0) |-> (irq_sum == 4'b0000));
  assert_input_no_blink_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((dir_w & (pad_out ^ out_w)) == '0));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .din_w(din_w), .prev_w(prev_w), .cause_w(cause_w),
  .out_w(out_w), .dir_w(dir_w), .blink_w(blink_w),
  .emask_w(emask_w), .lmask_w(lmask_w),
  .pad_out(pad_out), .irq_sum(irq_sum)
);

// File: tb/gpio_irq_bank_test.sv
module gpio_irq_bank_test;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] pad_in = '0;
  logic [31:0] rd_data, pad_out, pad_oe;
  logic        rd_valid;
  logic [3:0]  irq_sum;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  gpio_irq_bank #(.BLINK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .irq_sum(irq_sum)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read results (R10)
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10 unexpected rd_valid", rd_data, 32'h0);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(rd_data === e, t, rd_data, e);
      end
    end
  end

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      summary();
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    chk(pad_oe == 32'h0, "R1 pad_oe", pad_oe, 32'h0);
    chk(irq_sum == 4'h0, "R1 irq_sum", {28'h0, irq_sum}, 32'h0);
    bus_rd(3'd0, 32'h0, "R1 out reset");
    bus_rd(3'd1, 32'hFFFF_FFFF, "R1 dir reset");
    bus_rd(3'd2, 32'h0, "R1 blink reset");
    bus_rd(3'd3, 32'h0, "R1 pol reset");
    bus_rd(3'd5, 32'h0, "R1 cause reset");
    bus_rd(3'd6, 32'h0, "R1 emask reset");
    bus_rd(3'd7, 32'h0, "R1 lmask reset");

    // R2 / R3 register map, readback and direction
    bus_wr(3'd0, 32'hA5A5_5A5A);
    bus_wr(3'd1, 32'hFFFF_0000);
    bus_rd(3'd0, 32'hA5A5_5A5A, "R2 out readback");
    bus_rd(3'd1, 32'hFFFF_0000, "R2 dir readback");
    idle(1);
    chk(pad_oe == 32'h0000_FFFF, "R3 pad_oe", pad_oe, 32'h0000_FFFF);
    chk(pad_out[15:0] == 16'h5A5A, "R3 pad_out", {16'h0, pad_out[15:0]}, 32'h5A5A);
    bus_wr(3'd4, 32'hFFFF_FFFF);
    bus_rd(3'd4, 32'h0, "R2 data-in write ignored");

    // R4 polarity
    pad_in = 32'h0000_00F0;
    bus_wr(3'd3, 32'h0000_000F);
    idle(4);
    bus_rd(3'd4, 32'h0000_00FF, "R4 data-in xor polarity");
    bus_rd(3'd5, 32'h0000_00FF, "R5 edges from pad and polarity");
    bus_wr(3'd5, 32'h0);
    bus_rd(3'd5, 32'h0, "R6 clear all");
    pad_in = 32'h0;
    bus_wr(3'd3, 32'h0);
    idle(4);
    bus_rd(3'd5, 32'h0, "R5 falling sets nothing");

    // R5 / R6 / R7 edge path on line 9
    pad_in[9] = 1'b1;
    idle(4);
    bus_rd(3'd5, 32'h0000_0200, "R5 rising edge line 9");
    chk(irq_sum == 4'h0, "R7 unmasked edge quiet", {28'h0, irq_sum}, 32'h0);
    bus_wr(3'd6, 32'h0000_0200);
    chk(irq_sum == 4'b0010, "R7 edge group 1", {28'h0, irq_sum}, 32'h2);
    bus_wr(3'd5, 32'hFFFF_FDFF);
    chk(irq_sum == 4'h0, "R6 ack line 9", {28'h0, irq_sum}, 32'h0);
    bus_rd(3'd5, 32'h0, "R6 cause after ack");
    pad_in[9] = 1'b0;
    idle(4);
    bus_rd(3'd5, 32'h0, "R5 falling line 9");

    // R7 level path on line 30
    bus_wr(3'd7, 32'h4000_0000);
    pad_in[20] = 1'b1;
    idle(3);
    chk(irq_sum == 4'h0, "R7 level unmasked line", {28'h0, irq_sum}, 32'h0);
    pad_in[30] = 1'b1;
    idle(3);
    chk(irq_sum == 4'b1000, "R7 level group 3", {28'h0, irq_sum}, 32'h8);
    pad_in[30] = 1'b0;
    pad_in[20] = 1'b0;
    idle(3);
    chk(irq_sum == 4'h0, "R7 level release", {28'h0, irq_sum}, 32'h0);
    bus_rd(3'd5, 32'h4010_0000, "R5 cause lines 20 and 30");

    // R8 set beats clear: pad rises, write lands in the setting clock
    pad_in[3] = 1'b1;
    idle(2);
    bus_wr(3'd5, 32'h0);
    bus_rd(3'd5, 32'h0000_0008, "R8 set wins, others cleared");
    bus_wr(3'd5, 32'h0);
    pad_in[3] = 1'b0;

    // R9 blink on output line 0 and input line 20
    bus_wr(3'd2, 32'h0010_0001);
    begin
      automatic logic last = pad_out[0];
      automatic int t0 = -1;
      automatic int gap = 0;
      automatic bit in_ok = 1'b1;
      automatic bit b1_ok = 1'b1;
      for (int c = 0; c < 6 * DIV; c++) begin
        @(negedge clk);
        if (pad_out[20] !== 1'b0) in_ok = 1'b0;
        if (pad_out[1] !== 1'b1) b1_ok = 1'b0;
        if (pad_out[0] !== last) begin
          if (t0 >= 0 && gap == 0) gap = c - t0;
          t0 = c;
          last = pad_out[0];
        end
      end
      chk(gap == DIV, "R9 blink period", gap, DIV);
      chk(in_ok, "R9 input line unaffected", pad_out[20], 32'h0);
      chk(b1_ok, "R9 non-blink line steady", pad_out[1], 32'h1);
    end
    bus_wr(3'd2, 32'h0);
    idle(1);
    chk(pad_out[0] == 1'b0, "R9 blink off", pad_out[0], 32'h0);

    idle(3);
    chk(exp_q.size() == 0, "R10 all reads returned", exp_q.size(), 32'h0);
    done = 1;
    summary();
  end
endmodule